// File: doc/BRIEF.md
# Serial Control Word Receiver with Staging Register

This block receives 16-bit control words over a three-wire serial port (an active-low frame select, a serial clock and a data line) and turns each word into a command, a destination address and an 8-bit payload. All of its state is clocked on falling serial clock edges. The serial clock may run freely or idle at either level between frames.

Two 8-bit payloads build one 16-bit value in a staging register with a low half and a high half. A deferred write only fills one half. A direct write fills one half and then moves the whole 16-bit staging value into the data register. It also flips a commit toggle so that a downstream synchronizer can pick up the data, the address and the command. The staging halves keep their contents after a commit, so one later direct write can change one byte of a destination. Control-flag and select-flag writes put their payload through the same commit path. Crossing into the master clock domain and the destination register bank are left to downstream logic.

Top module: `serial_defer_if`

## Requirements
- R1: After reset, data_o, addr_o, cmd_o and commit_tgl_o are all zero.
- R2: Bits are taken MSB first, one per falling serial clock edge while fsync_ni is low. Word bits [15:12] are the command, bits [11:8] the address and bits [7:0] the payload.
- R3: Command 0000 loads the payload into the low staging half and command 0010 loads it into the high staging half. Neither command changes data_o, addr_o, cmd_o or commit_tgl_o.
- R4: Command 0001 loads the payload into the low half and sets data_o = {high half, payload}. It sets addr_o and cmd_o from the word and inverts commit_tgl_o.
- R5: Command 0011 loads the payload into the high half and sets data_o = {payload, low half}. It sets addr_o and cmd_o from the word and inverts commit_tgl_o.
- R6: The staging halves keep their values after a commit. A later direct write to the other half commits the new byte together with the byte that was staged earlier.
- R7: Command 0100 (control flags) and command 0101 (select flags) set data_o = {8'h00, payload}, set addr_o and cmd_o, and invert commit_tgl_o. Both staging halves stay unchanged.
- R8: Commands 0110 to 1111 change no output and no staging half.
- R9: If fsync_ni rises before the 16th falling edge, the partial word is discarded. No output changes, and the next frame starts again from bit 15.
- R10: Falling edges after the 16th in the same frame are ignored.
- R11: Outputs change at the 16th falling edge of a frame and at no earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data sampled on falling edges |
| fsync_ni | input | 1 | Frame select, low during a frame |
| sdata_i | input | 1 | Serial data, MSB first |
| data_o | output | 16 | Committed data word |
| addr_o | output | 4 | Address of the last committed word |
| cmd_o | output | 4 | Command of the last committed word |
| commit_tgl_o | output | 1 | Inverts once per committed word |

## Verification
A staging half that holds a wrong value shows up only at the next direct write to the opposite half: that commit's data_o carries the stale byte. The bench therefore follows staged writes with direct writes to the other half, both in directed sequences and in the random mix. A bit counter that is wrong shows within one frame: a shifted address or command, a toggle at the wrong edge, or a missing or extra toggle after an aborted frame or an overrun frame. The directed edge-by-edge frame checks the toggle after the 15th and after the 16th edge.

// File: rtl/sdefer_pkg.sv
package sdefer_pkg;
  localparam int unsigned CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_DEF_LO = 4'h0,
    CMD_DIR_LO = 4'h1,
    CMD_DEF_HI = 4'h2,
    CMD_DIR_HI = 4'h3,
    CMD_CTRL   = 4'h4,
    CMD_SEL    = 4'h5
  } cmd_e;
endpackage

// File: rtl/sdefer_shift.sv
module sdefer_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_ni,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;
  logic              arst_n;

  // idle frame select clears the partial word asynchronously
  assign arst_n = rst_ni & ~fsync_ni;

  always_ff @(negedge sclk_i or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cnt_q != CNT_W'(WORD_W)) begin
      cnt_q <= cnt_q + CNT_W'(1);
      sh_q  <= {sh_q[WORD_W-3:0], sdata_i};
    end
  end

  assign word_o = {sh_q, sdata_i};
  assign last_o = ~fsync_ni & (cnt_q == CNT_W'(WORD_W - 1));
endmodule

// File: rtl/sdefer_dec.sv
module sdefer_dec
  import sdefer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAY_W  = 8,
  localparam int unsigned WORD_W = CMD_W + ADDR_W + PAY_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAY_W-1:0]  pay_o,
  output logic              is_data_o,
  output logic              half_o,
  output logic              is_cfg_o,
  output logic              commit_o
);
  assign cmd_o  = word_i[WORD_W-1 -: CMD_W];
  assign addr_o = word_i[PAY_W +: ADDR_W];
  assign pay_o  = word_i[PAY_W-1:0];

  always_comb begin
    is_data_o = 1'b0;
    half_o    = 1'b0;
    is_cfg_o  = 1'b0;
    commit_o  = 1'b0;
    unique case (cmd_o)
      CMD_DEF_LO: is_data_o = 1'b1;
      CMD_DIR_LO: begin is_data_o = 1'b1; commit_o = 1'b1; end
      CMD_DEF_HI: begin is_data_o = 1'b1; half_o = 1'b1; end
      CMD_DIR_HI: begin is_data_o = 1'b1; half_o = 1'b1; commit_o = 1'b1; end
      CMD_CTRL,
      CMD_SEL:    begin is_cfg_o = 1'b1; commit_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_defer_if.sv
module serial_defer_if
  import sdefer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAY_W  = 8
) (
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 fsync_ni,
  input  logic                 sdata_i,
  output logic [2*PAY_W-1:0]   data_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic                 commit_tgl_o
);
  localparam int unsigned WORD_W = CMD_W + ADDR_W + PAY_W;
  localparam int unsigned NH     = 2;
  localparam int unsigned DATA_W = NH * PAY_W;

  logic [WORD_W-1:0] word_w;
  logic              last_w;
  logic [CMD_W-1:0]  dec_cmd;
  logic [ADDR_W-1:0] dec_addr;
  logic [PAY_W-1:0]  dec_pay;
  logic              dec_data, dec_half, dec_cfg, dec_commit;

  logic [NH-1:0][PAY_W-1:0] defer_w;
  logic [NH-1:0][PAY_W-1:0] defer_nx;

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              tgl_q;

  sdefer_shift #(.WORD_W(WORD_W)) u_shift (
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .fsync_ni(fsync_ni),
    .sdata_i (sdata_i),
    .word_o  (word_w),
    .last_o  (last_w)
  );

  sdefer_dec #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_dec (
    .word_i   (word_w),
    .cmd_o    (dec_cmd),
    .addr_o   (dec_addr),
    .pay_o    (dec_pay),
    .is_data_o(dec_data),
    .half_o   (dec_half),
    .is_cfg_o (dec_cfg),
    .commit_o (dec_commit)
  );

  for (genvar h = 0; h < NH; h++) begin : gen_half
    logic [PAY_W-1:0] q;
    logic             hit;

    assign hit = dec_data & (dec_half == 1'(h));

    always_ff @(negedge sclk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (last_w && hit) q <= dec_pay;
    end

    assign defer_w[h]  = q;
    // value the half holds after this word, used by a same-edge commit
    assign defer_nx[h] = hit ? dec_pay : q;
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      tgl_q  <= 1'b0;
    end else if (last_w && dec_commit) begin
      data_q <= dec_cfg ? DATA_W'(dec_pay) : defer_nx;
      addr_q <= dec_addr;
      cmd_q  <= dec_cmd;
      tgl_q  <= ~tgl_q;
    end
  end

  assign data_o       = data_q;
  assign addr_o       = addr_q;
  assign cmd_o        = cmd_q;
  assign commit_tgl_o = tgl_q;
endmodule

// File: rtl/sdefer_chk.sv
module sdefer_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAY_W  = 8
) (
  input logic                rst_ni,
  input logic                sclk_i,
  input logic                word_vld,
  input logic [WORD_W-1:0]   word,
  input logic [2*PAY_W-1:0]  data_o,
  input logic                commit_tgl_o
);
  logic [3:0] c;
  assign c = word[WORD_W-1 -: 4];

  // R3: staged writes leave the committed outputs alone
  p_staged_hold_r3: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_vld && (c == 4'h0 || c == 4'h2)) |=> ($stable(data_o) && $stable(commit_tgl_o)));

  // R4
  p_direct_lo_r4: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_vld && c == 4'h1) |=>
      (data_o[PAY_W-1:0] == $past(word[PAY_W-1:0]) && commit_tgl_o != $past(commit_tgl_o)));

  // R5
  p_direct_hi_r5: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_vld && c == 4'h3) |=>
      (data_o[2*PAY_W-1:PAY_W] == $past(word[PAY_W-1:0]) && commit_tgl_o != $past(commit_tgl_o)));

  // R8
  p_unknown_cmd_r8: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_vld && c > 4'h5) |=> ($stable(data_o) && $stable(commit_tgl_o)));

  // R11 (also R9, R10): no toggle without a completed word
  p_no_early_commit_r11: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    !word_vld |=> $stable(commit_tgl_o));
endmodule

bind serial_defer_if sdefer_chk #(.WORD_W(WORD_W), .PAY_W(PAY_W)) chk_i (
  .rst_ni      (rst_ni),
  .sclk_i      (sclk_i),
  .word_vld    (last_w),
  .word        (word_w),
  .data_o      (data_o),
  .commit_tgl_o(commit_tgl_o)
);

// File: tb/serial_defer_if_tb.sv
module serial_defer_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = CLK_PERIOD / 2;

  logic        rst_ni = 1'b0;
  logic        sclk = 1'b1;
  logic        fsync_n = 1'b1;
  logic        sdata = 1'b0;
  logic [15:0] data_o;
  logic [3:0]  addr_o, cmd_o;
  logic        commit_tgl_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  idle_hi = 1'b1;

  logic [7:0]  m_lo = '0, m_hi = '0;
  logic [15:0] m_data = '0;
  logic [3:0]  m_addr = '0, m_cmd = '0;
  logic        m_tgl = 1'b0;

  serial_defer_if dut_i (
    .rst_ni(rst_ni), .sclk_i(sclk), .fsync_ni(fsync_n), .sdata_i(sdata),
    .data_o(data_o), .addr_o(addr_o), .cmd_o(cmd_o), .commit_tgl_o(commit_tgl_o)
  );

  function automatic void model_apply(input logic [15:0] w);
    logic [3:0] c = w[15:12];
    logic [7:0] p = w[7:0];
    bit commit = 1'b0;
    case (c)
      4'h0: m_lo = p;
      4'h1: begin m_lo = p; m_data = {m_hi, p}; commit = 1'b1; end
      4'h2: m_hi = p;
      4'h3: begin m_hi = p; m_data = {p, m_lo}; commit = 1'b1; end
      4'h4, 4'h5: begin m_data = {8'h00, p}; commit = 1'b1; end
      default: ;
    endcase
    if (commit) begin
      m_addr = w[11:8];
      m_cmd  = c;
      m_tgl  = ~m_tgl;
    end
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h0, 4'h2: return "R3";
      4'h1:       return "R4";
      4'h3:       return "R5";
      4'h4, 4'h5: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "data", 32'(data_o), 32'(m_data));
    chk(req, "addr", 32'(addr_o), 32'(m_addr));
    chk(req, "cmd",  32'(cmd_o),  32'(m_cmd));
    chk(req, "tgl",  32'(commit_tgl_o), 32'(m_tgl));
  endtask

  task automatic set_idle(input bit hi);
    idle_hi = hi;
    sclk = hi;
    #H;
  endtask

  task automatic clk_bit(input logic b);
    sdata = b;
    if (idle_hi) begin
      #H; sclk = 1'b0; #H; sclk = 1'b1;
    end else begin
      sclk = 1'b1; #H; sclk = 1'b0; #H;
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    fsync_n = 1'b0;
    #H;
    for (int i = 0; i < nbits; i++) clk_bit(w[15-i]);
    for (int i = 0; i < extra; i++) clk_bit(1'($urandom_range(1)));
    #H;
    fsync_n = 1'b1;
    #H;
    if (nbits == 16) model_apply(w);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(3 * CLK_PERIOD);
    chk_all("R1");
    rst_ni = 1'b1;
    #(2 * CLK_PERIOD);
    chk_all("R1");

    // R11: nothing changes through edge 15, commit at edge 16
    begin
      logic [15:0] w = 16'h1277;
      fsync_n = 1'b0;
      #H;
      for (int i = 0; i < 15; i++) clk_bit(w[15-i]);
      #1;
      chk("R11", "tgl_edge15", 32'(commit_tgl_o), 32'(m_tgl));
      chk("R11", "data_edge15", 32'(data_o), 32'(m_data));
      clk_bit(w[0]);
      #1;
      model_apply(w);
      chk_all("R11");
      #H;
      fsync_n = 1'b1;
      #H;
    end

    // R2: field positions, MSB first
    send(16'h1A5C, 16, 0);
    chk_all("R2");
    chk("R2", "addr_field", 32'(addr_o), 32'h0A);
    chk("R2", "cmd_field", 32'(cmd_o), 32'h01);

    // R3 then R5 then R6 with the clock idling low
    set_idle(1'b0);
    send(16'h03AB, 16, 0);
    chk_all("R3");
    send(16'h33CD, 16, 0);
    chk_all("R5");
    chk("R5", "data_hi_lo", 32'(data_o), 32'hCDAB);
    send(16'h13EF, 16, 0);
    chk_all("R6");
    chk("R6", "reuse_hi", 32'(data_o), 32'hCDEF);

    // R7: flag write keeps staging intact
    set_idle(1'b1);
    send(16'h4003, 16, 0);
    chk_all("R7");
    send(16'h1011, 16, 0);
    chk("R7", "staging_kept", 32'(data_o), 32'hCD11);

    // R8
    send(16'h9F77, 16, 0);
    chk_all("R8");

    // R9: abort then a fresh frame
    send(16'h3155, 9, 0);
    chk_all("R9");
    send(16'h0266, 16, 0);
    send(16'h1299, 16, 0);
    chk_all("R9");

    // R10: overrun edges
    send(16'h35A1, 16, 7);
    chk_all("R10");

    for (int k = 0; k < 300; k++) begin
      logic [15:0] w;
      int mode;
      w = {4'($urandom_range(7)), 4'($urandom), 8'($urandom)};
      if ($urandom_range(15) == 0) set_idle(~idle_hi);
      mode = $urandom_range(9);
      if (mode == 0) begin
        send(w, $urandom_range(15, 1), 0);
        chk_all("R9");
      end else if (mode == 1) begin
        send(w, 16, $urandom_range(6, 1));
        chk_all("R10");
      end else begin
        send(w, 16, 0);
        chk_all(tag_of(w[15:12]));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule